// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the integer execute stage of a 32-bit core. Each cycle it can accept one decoded operation: a 6-bit opcode, two register operands and a 16-bit immediate. It computes one of unsigned or signed add and subtract, logical shifts, an arithmetic right shift, bitwise logic (including forms that place the immediate in the upper half-word), or a combined loop step. The loop step adds its two operands and reports whether a loop branch is taken. The register file and the branch-target adder sit outside the block. The block drives only the result, a destination write strobe, the condition flag and the loop-taken strobe.

The block holds two flags. The condition flag (`out_cc`) changes meaning with the operation: carry, sign, less-than or zero. The loop flag is internal. It follows its own rule, which depends on the sign of the operand, and the loop branch decision uses the value the flag had before the current instruction. Input is a plain valid strobe with no back-pressure. An operation is accepted in every cycle where `in_valid` is high, and its results are registered and appear together, one cycle later, under `out_valid`.

Top module: `int_exec_cc`

## Requirements
- R1: After reset, `out_valid`, `out_wr`, `out_cc` and `out_loop_take` are 0 and the loop flag is 0, so the first loop step after reset is not taken.
- R2: Odd arithmetic opcodes (0x21, 0x23, 0x25, 0x27) take the sign-extended immediate as the first operand. Odd logical opcodes take the immediate zero-extended. Even opcodes take `in_rs1`. The second operand is always `in_rs2`.
- R3: Opcodes 0x20/0x21 (unsigned add) and 0x24/0x25 (signed add) return first + second. Opcodes 0x22/0x23 (unsigned subtract) and 0x26/0x27 (signed subtract) return first − second. All four write.
- R4: Condition flag for arithmetic: unsigned add gives the carry out of bit 31, signed add gives bit 31 of the sum, unsigned subtract gives first < second unsigned, and signed subtract gives first < second signed.
- R5: Opcode bits [3:2] of 0x30–0x3f pick the operation: 00 is second AND first, 01 is second AND NOT first, 10 is OR, 11 is XOR. When bit 1 is set and bit 0 is set, the immediate is shifted left by 16 before use. The result writes, and the condition flag becomes 1 exactly when the 32-bit result is zero.
- R6: Opcodes 0x28/0x29 shift the second operand left, 0x2a/0x2b shift it right logically, and 0x2e/0x2f shift it right arithmetically. The count is the low five bits of the first operand. The result writes and the condition flag is unchanged.
- R7: Opcode 0x2d (loop step) writes `in_rs1 + in_rs2` and never uses the immediate. `out_loop_take` equals the loop flag as it stood before this instruction. The condition flag is unchanged.
- R8: New loop flag: if `in_rs1` is negative, it is 1 when bit 31 of the wrapped sum is 0. Otherwise it is the carry out of the unsigned sum.
- R9: Outputs for an operation accepted at clock edge k are visible after edge k+1. In a cycle with `in_valid` low, `out_valid`, `out_wr` and `out_loop_take` go to 0, and both flags hold.
- R10: Opcodes 0x00–0x1f and 0x2c write nothing and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 6 | Decoded opcode |
| in_rs1 | input | 32 | First register operand |
| in_rs2 | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Registered copy of in_valid |
| out_result | output | 32 | Result for the destination register |
| out_wr | output | 1 | Destination write strobe |
| out_cc | output | 1 | Condition flag |
| out_loop_take | output | 1 | Loop branch taken |

## Verification
Every result, the write strobe, the condition flag and the loop-taken strobe are due exactly one edge after the operation is presented. The bench changes inputs on the falling edge and compares all outputs at the next falling edge, which is the first point where that edge's registers are settled. A change to the loop flag becomes visible only through the `out_loop_take` of the next loop step, so the directed sequences issue loop steps back to back and check the take decision of each one against the flag the model produced for the step before.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_ADDU  = 6'h20;
  localparam logic [OP_W-1:0] OP_SUBU  = 6'h22;
  localparam logic [OP_W-1:0] OP_ADDS  = 6'h24;
  localparam logic [OP_W-1:0] OP_SUBS  = 6'h26;
  localparam logic [OP_W-1:0] OP_SHL   = 6'h28;
  localparam logic [OP_W-1:0] OP_SHR   = 6'h2a;
  localparam logic [OP_W-1:0] OP_RSV   = 6'h2c;
  localparam logic [OP_W-1:0] OP_LOOP  = 6'h2d;
  localparam logic [OP_W-1:0] OP_SHRA  = 6'h2e;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ARITH,
    CLS_SHIFT,
    CLS_LOGIC,
    CLS_LOOP
  } op_class_e;
endpackage

// File: rtl/ialu_opsel.sv
module ialu_opsel
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] rs1,
  input  logic [IMM_W-1:0]  imm,
  output op_class_e         cls,
  output logic [DATA_W-1:0] opa
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] imm_zx;
  logic [DATA_W-1:0] imm_hi;

  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{EXT_W{1'b0}}, imm};
  assign imm_hi = imm_zx << IMM_W;

  always_comb begin
    cls = CLS_NONE;
    if (op == OP_LOOP)                       cls = CLS_LOOP;
    else if (op[5:4] == 2'b11)               cls = CLS_LOGIC;
    else if (op[5:3] == 3'b100)              cls = CLS_ARITH;
    else if (op[5:3] == 3'b101 && op[2:1] != 2'b10) cls = CLS_SHIFT;
  end

  always_comb begin
    opa = rs1;
    if (op[0] && cls != CLS_LOOP) begin
      unique case (cls)
        CLS_ARITH: opa = imm_sx;
        CLS_LOGIC: opa = op[1] ? imm_hi : imm_zx;
        default:   opa = imm_zx;
      endcase
    end
  end
endmodule

// File: rtl/ialu_arith.sv
module ialu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] res,
  output logic              flag,
  output logic [DATA_W-1:0] loop_sum,
  output logic              loop_flag
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sum_ext;
  logic [DATA_W-1:0] dif;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign dif     = a - b;

  always_comb begin
    unique case (sel)
      2'b00: begin res = sum_ext[MSB:0]; flag = sum_ext[DATA_W]; end
      2'b01: begin res = dif; flag = (a < b); end
      2'b10: begin res = sum_ext[MSB:0]; flag = sum_ext[MSB]; end
      default: begin res = dif; flag = ($signed(a) < $signed(b)); end
    endcase
  end

  assign loop_sum  = sum_ext[MSB:0];
  assign loop_flag = a[MSB] ? ~sum_ext[MSB] : sum_ext[DATA_W];
endmodule

// File: rtl/ialu_bitops.sv
module ialu_bitops #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        fn,
  output logic [DATA_W-1:0] logic_res,
  output logic              logic_zero,
  output logic [DATA_W-1:0] shift_res
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] shamt;
  assign shamt = a[SH_W-1:0];

  always_comb begin
    unique case (fn[2:1])
      2'b00:   logic_res = b & a;
      2'b01:   logic_res = b & ~a;
      2'b10:   logic_res = b | a;
      default: logic_res = b ^ a;
    endcase
  end

  assign logic_zero = (logic_res == '0);

  always_comb begin
    unique case (fn[1:0])
      2'b00:   shift_res = b << shamt;
      2'b11:   shift_res = DATA_W'($signed(b) >>> shamt);
      default: shift_res = b >> shamt;
    endcase
  end
endmodule

// File: rtl/int_exec_cc.sv
module int_exec_cc
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_rs1,
  input  logic [DATA_W-1:0] in_rs2,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr,
  output logic              out_cc,
  output logic              out_loop_take
);
  op_class_e         cls;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] ar_res, lp_sum, lg_res, sh_res;
  logic              ar_flag, lp_flag, lg_zero;
  logic              lcc_q;

  logic [DATA_W-1:0] res_n;
  logic              wr_n, cc_n, cc_upd;

  ialu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .op  (in_op),
    .rs1 (in_rs1),
    .imm (in_imm),
    .cls (cls),
    .opa (opa)
  );

  ialu_arith #(.DATA_W(DATA_W)) u_arith (
    .a         (opa),
    .b         (in_rs2),
    .sel       (in_op[2:1]),
    .res       (ar_res),
    .flag      (ar_flag),
    .loop_sum  (lp_sum),
    .loop_flag (lp_flag)
  );

  ialu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .a          (opa),
    .b          (in_rs2),
    .fn         (in_op[3:1]),
    .logic_res  (lg_res),
    .logic_zero (lg_zero),
    .shift_res  (sh_res)
  );

  always_comb begin
    res_n  = '0;
    wr_n   = 1'b1;
    cc_n   = 1'b0;
    cc_upd = 1'b0;
    unique case (cls)
      CLS_ARITH: begin res_n = ar_res; cc_n = ar_flag; cc_upd = 1'b1; end
      CLS_LOGIC: begin res_n = lg_res; cc_n = lg_zero; cc_upd = 1'b1; end
      CLS_SHIFT: res_n = sh_res;
      CLS_LOOP:  res_n = lp_sum;
      default:   wr_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_wr        <= 1'b0;
      out_cc        <= 1'b0;
      out_loop_take <= 1'b0;
      lcc_q         <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= res_n;
        out_wr        <= wr_n;
        out_loop_take <= (cls == CLS_LOOP) && lcc_q;
        if (cc_upd)          out_cc <= cc_n;
        if (cls == CLS_LOOP) lcc_q  <= lp_flag;
      end else begin
        out_wr        <= 1'b0;
        out_loop_take <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ialu_checker.sv
module ialu_checker
  import ialu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OP_W-1:0] in_op,
  input logic            out_valid,
  input logic            out_wr,
  input logic            out_cc,
  input logic            out_loop_take
);
  logic is_shift;
  assign is_shift = in_op inside {6'h28, 6'h29, 6'h2a, 6'h2b, 6'h2e, 6'h2f};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_wr && !out_loop_take)); // R9
  AST_IDLE_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_cc)); // R9
  AST_SHIFT_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_shift) |=> $stable(out_cc)); // R6
  AST_LOOP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_LOOP) |=> (out_wr && $stable(out_cc))); // R7
  AST_TAKE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_loop_take |-> out_wr); // R7
  AST_RSV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!in_op[5] || in_op == OP_RSV)) |=> (!out_wr && $stable(out_cc))); // R10
endmodule

bind int_exec_cc ialu_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_op         (in_op),
  .out_valid     (out_valid),
  .out_wr        (out_wr),
  .out_cc        (out_cc),
  .out_loop_take (out_loop_take)
);

// File: tb/int_exec_cc_test.sv
module int_exec_cc_test;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  in_op = '0;
  logic [31:0] in_rs1 = '0, in_rs2 = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid, out_wr, out_cc, out_loop_take;
  logic [31:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic cc_m = 1'b0;
  logic lcc_m = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  int_exec_cc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm),
    .out_valid(out_valid), .out_result(out_result), .out_wr(out_wr),
    .out_cc(out_cc), .out_loop_take(out_loop_take)
  );

  function automatic string tag_of(input logic [5:0] op);
    if (!op[5] || op == 6'h2c) return "R10";
    if (op == 6'h2d)           return "R7";
    if (op[5:3] == 3'b100)     return "R3";
    if (op[5:4] == 2'b11)      return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic model(input logic [5:0] op, input logic [31:0] r1, r2, input logic [15:0] im,
                       output logic [31:0] res, output logic wr, output logic take);
    logic [31:0] a;
    logic [32:0] s;
    res = '0; wr = 1'b1; take = 1'b0;
    if (!op[5] || op == 6'h2c) begin
      wr = 1'b0;
    end else if (op == 6'h2d) begin
      s = {1'b0, r1} + {1'b0, r2};
      res = s[31:0];
      take = lcc_m;
      lcc_m = r1[31] ? ~s[31] : s[32];
    end else if (op[5:3] == 3'b100) begin
      a = op[0] ? {{16{im[15]}}, im} : r1;
      s = {1'b0, a} + {1'b0, r2};
      case (op[2:1])
        2'b00: begin res = s[31:0]; cc_m = s[32]; end
        2'b01: begin res = a - r2; cc_m = (a < r2); end
        2'b10: begin res = s[31:0]; cc_m = s[31]; end
        default: begin res = a - r2; cc_m = ($signed(a) < $signed(r2)); end
      endcase
    end else if (op[5:4] == 2'b11) begin
      a = op[0] ? (op[1] ? {im, 16'h0} : {16'h0, im}) : r1;
      case (op[3:2])
        2'b00: res = r2 & a;
        2'b01: res = r2 & ~a;
        2'b10: res = r2 | a;
        default: res = r2 ^ a;
      endcase
      cc_m = (res == 32'h0);
    end else begin
      a = op[0] ? {16'h0, im} : r1;
      case (op[2:1])
        2'b00: res = r2 << a[4:0];
        2'b11: res = $signed(r2) >>> a[4:0];
        default: res = r2 >> a[4:0];
      endcase
    end
  endtask

  // Called at a falling edge; result is due after the next rising edge.
  task automatic issue(input logic [5:0] op, input logic [31:0] r1, r2, input logic [15:0] im);
    logic [31:0] e_res; logic e_wr, e_take;
    string t;
    t = tag_of(op);
    model(op, r1, r2, im, e_res, e_wr, e_take);
    in_valid = 1'b1; in_op = op; in_rs1 = r1; in_rs2 = r2; in_imm = im;
    @(negedge clk);
    check("R9", "out_valid", 32'(out_valid), 32'd1);
    check(t, "out_wr", 32'(out_wr), 32'(e_wr));
    if (e_wr) check(t, "out_result", out_result, e_res);
    check(op == 6'h2d ? "R8" : (op[5:3] == 3'b100 ? "R4" : t), "out_cc", 32'(out_cc), 32'(cc_m));
    check(op == 6'h2d ? "R8" : t, "out_loop_take", 32'(out_loop_take), 32'(e_take));
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_op = 6'h20; in_rs1 = 32'hffffffff; in_rs2 = 32'h1;
    @(negedge clk);
    check("R9", "idle out_valid", 32'(out_valid), 32'd0);
    check("R9", "idle out_wr", 32'(out_wr), 32'd0);
    check("R9", "idle out_cc", 32'(out_cc), 32'(cc_m));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", 32'(out_valid), 32'd0);
    check("R1", "out_wr", 32'(out_wr), 32'd0);
    check("R1", "out_cc", 32'(out_cc), 32'd0);
    check("R1", "out_loop_take", 32'(out_loop_take), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first loop step after reset is not taken
    issue(6'h2d, 32'h00000001, 32'hffffffff, 16'h0);   // R8 carry -> flag 1
    issue(6'h2d, 32'hffffffff, 32'h00000005, 16'h0);   // R7 taken, R8 neg rs1 sum>=0 -> 1
    issue(6'h2d, 32'hffffffff, 32'hffffffff, 16'h0);   // R8 sum negative -> 0
    issue(6'h2d, 32'h00000003, 32'h00000004, 16'hffff); // R7 not taken, imm ignored
    issue(6'h2d, 32'h0, 32'h0, 16'h0);
    // R3/R4 corners
    issue(6'h20, 32'hffffffff, 32'h1, 16'h0);
    issue(6'h25, 32'h0, 32'h7fffffff, 16'h0001);
    issue(6'h22, 32'h1, 32'h2, 16'h0);
    issue(6'h27, 32'h0, 32'h0, 16'hffff);   // R2 sign-extended -1 - 0
    issue(6'h23, 32'h0, 32'h5, 16'h8000);   // R2
    issue(6'h26, 32'h80000000, 32'h1, 16'h0);
    // R5 logical, high forms, zero flag
    issue(6'h3b, 32'h0, 32'h0000abcd, 16'h1234);
    issue(6'h3d, 32'h0, 32'h0000ffff, 16'hffff);
    issue(6'h31, 32'h0, 32'hffffffff, 16'h8000); // R2 zero-extended
    issue(6'h37, 32'h0, 32'hffffffff, 16'hffff);
    issue(6'h34, 32'h0f0f0f0f, 32'h0f0f0f0f, 16'h0);
    // R6 shifts, count masked to 5 bits, flag held
    issue(6'h2e, 32'd33, 32'h80000000, 16'h0);
    issue(6'h29, 32'h0, 32'h1, 16'h001f);
    issue(6'h2b, 32'h0, 32'h80000000, 16'h0024);
    // R10 reserved codes
    issue(6'h2c, 32'h5, 32'h5, 16'h0);
    issue(6'h05, 32'h0, 32'h0, 16'h0);
    idle();
    idle();
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op; logic [31:0] a, b; logic [15:0] im;
      op = 6'($urandom_range(0, 63));
      if (($urandom & 3) == 0) op = 6'h2d;
      a = $urandom; b = $urandom; im = 16'($urandom);
      case ($urandom & 7)
        0: a = 32'hffffffff;
        1: b = 32'h0;
        2: b = a;
        3: b = 32'h80000000;
        default: ;
      endcase
      if (($urandom & 15) == 0) idle();
      issue(op, a, b, im);
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule